// File: doc/BRIEF.md
# Bit-Serial Adder with Selectable Carry Storage

This block adds two unsigned operands one bit position per clock cycle, starting at the least significant bit. In each cycle where the caller marks the inputs as valid, the block takes one bit of each operand and returns the matching sum bit. The carry between bit positions lives in a single-bit register. A start strobe loads the external carry-in into that register before the first bit is presented. After the last bit, the registered carry is the carry-out of the whole word.

The caller owns word framing. It shifts the operand bits in, counts the word length and gathers the sum bits. The block only holds the carry. A parameter picks how the carry register is built. One option is a plain data flip-flop that loads the majority of the three inputs. The other is a set/reset element that is set when both operand bits are 1, cleared when both are 0, and left unchanged when they differ.

Top module: `bitser_adder`

## Requirements
- R1: While `rst_n` is low, the carry register and `cout_o` are 0. Release of reset is synchronised to `clk` and takes effect two cycles after `rst_n` rises.
- R2: A cycle with `start_i`=1 loads `cin_i` into the carry. `cout_o` shows it after the next rising edge. `start_i` wins over `valid_i` in the same cycle.
- R3: `sum_o` is combinational and equals `a_i` XOR `b_i` XOR the current carry in every cycle.
- R4: A cycle with `valid_i`=1 and `start_i`=0 replaces the carry with the majority of `a_i`, `b_i` and the current carry.
- R5: In a cycle with `start_i`=0 and `valid_i`=0, the carry keeps its value whatever `a_i`, `b_i` and `cin_i` are.
- R6: With `CARRY_STYLE`=CARRY_SR (1), a valid bit pair of 1,1 sets the carry and 0,0 clears it. A pair whose bits differ leaves it unchanged. Set and clear are never requested together.
- R7: For an n-bit word, one start cycle followed by n valid cycles produces sum bits equal to bits 0 to n-1 of a+b+cin, in that order. After the last valid cycle, `cout_o` equals bit n. Both carry styles give identical results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Loads `cin_i` into the carry register |
| cin_i | input | 1 | Initial carry for the next word |
| valid_i | input | 1 | Current `a_i`/`b_i` pair is a bit slice to add |
| a_i | input | 1 | Serial bit of operand A |
| b_i | input | 1 | Serial bit of operand B |
| sum_o | output | 1 | Sum bit for the current slice (combinational) |
| cout_o | output | 1 | Registered carry; carry-out after the last slice |

## Verification
The bench adds every pair of 4-bit operands with both carry-in values. This covers every combination of bit pair and incoming carry, and it separates a majority update from a plain copy of either operand. Wide 24-bit words of all ones with carry-in 1 make a carry ripple through every position. Random 16-bit words mix propagate, generate and kill slices. Directed cycles test start against valid in the same cycle, idle cycles with active operand bits, unequal bit pairs that must hold the carry in the set/reset style, and a reset during a word. Both carry styles run side by side against one behavioural model.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  typedef enum logic {
    CARRY_DFF = 1'b0,
    CARRY_SR  = 1'b1
  } carry_style_e;

  typedef struct packed {
    logic sum;
    logic carry_nxt;
    logic set_req;
    logic clr_req;
  } slice_out_t;

endpackage

// File: rtl/bsa_rst_sync.sv
module bsa_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bsa_slice.sv
module bsa_slice
  import bsa_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       c,
  output slice_out_t o
);

  always_comb begin
    o.sum       = a ^ b ^ c;
    o.carry_nxt = (a & b) | (c & (a | b));
    o.set_req   = a & b;
    o.clr_req   = ~a & ~b;
  end

endmodule

// File: rtl/bsa_carry_reg.sv
module bsa_carry_reg
  import bsa_pkg::*;
#(
  parameter carry_style_e STYLE = CARRY_DFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_val,
  input  logic en,
  input  logic d,
  input  logic set_req,
  input  logic clr_req,
  output logic q
);

  logic q_nxt;
  logic upd;

  assign upd = load | en;

  generate
    if (STYLE == CARRY_DFF) begin : g_dff
      always_comb begin
        q_nxt = load ? load_val : d;
      end

      AST_DFF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && set_req) |=> q) else $error("dff set");        // R4
      AST_DFF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && clr_req) |=> !q) else $error("dff clear");     // R4
    end else begin : g_sr
      logic s_eff;
      logic r_eff;

      always_comb begin
        s_eff = en & set_req;
        r_eff = en & clr_req;
        if (load)       q_nxt = load_val;
        else if (s_eff) q_nxt = 1'b1;
        else if (r_eff) q_nxt = 1'b0;
        else            q_nxt = q;
      end

      AST_SR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_req && clr_req)) else $error("set and clear together");  // R6
      AST_SR_DIFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && !set_req && !clr_req) |=> $stable(q)) else $error("sr hold"); // R6
      AST_SR_MATCH_D: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load) |=> (q == $past(d))) else $error("sr vs majority"); // R7
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (upd) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/bitser_adder.sv
module bitser_adder
  import bsa_pkg::*;
#(
  parameter carry_style_e CARRY_STYLE = CARRY_DFF,
  parameter int unsigned  SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cin_i,
  input  logic valid_i,
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic cout_o
);

  logic       rst_sync_n;
  logic       carry_q;
  slice_out_t slice;

  bsa_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bsa_slice u_slice (
    .a (a_i),
    .b (b_i),
    .c (carry_q),
    .o (slice)
  );

  bsa_carry_reg #(.STYLE(CARRY_STYLE)) u_carry (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (start_i),
    .load_val (cin_i),
    .en       (valid_i),
    .d        (slice.carry_nxt),
    .set_req  (slice.set_req),
    .clr_req  (slice.clr_req),
    .q        (carry_q)
  );

  assign sum_o  = slice.sum;
  assign cout_o = carry_q;

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i |=> (cout_o == $past(cin_i))) else $error("start load");   // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!start_i && !valid_i) |=> $stable(cout_o)) else $error("idle hold"); // R5
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && !start_i) |=>
      (cout_o == (($past(a_i) & $past(b_i)) | ($past(cout_o) & ($past(a_i) | $past(b_i))))))
    else $error("carry update");                                        // R4
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> !cout_o)
    else $error("reset clear");                                         // R1

endmodule

// File: tb/tb_bitser_adder.sv
`timescale 1ns/1ps
module tb_bitser_adder;
  import bsa_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cin = 1'b0, valid = 1'b0, ain = 1'b0, bin = 1'b0;
  logic sum_d, cout_d, sum_s, cout_s;
  int   n_chk = 0;
  int   n_err = 0;
  int   model_c = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  bitser_adder #(.CARRY_STYLE(CARRY_DFF)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cin_i(cin), .valid_i(valid),
    .a_i(ain), .b_i(bin), .sum_o(sum_d), .cout_o(cout_d));

  bitser_adder #(.CARRY_STYLE(CARRY_SR)) dut_sr (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cin_i(cin), .valid_i(valid),
    .a_i(ain), .b_i(bin), .sum_o(sum_s), .cout_o(cout_s));

  task automatic check(input string what, input longint got, input longint exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%0h exp=%0h", what, got, exp);
    end
  endtask

  // One cycle: drive at negedge, compare both styles with the model, update model at posedge
  task automatic step(input logic st, input logic ci, input logic v,
                      input logic a, input logic b, input string tag, output logic s_out);
    int tot;
    @(negedge clk);
    start = st; cin = ci; valid = v; ain = a; bin = b;
    #1;
    tot = int'(a) + int'(b) + model_c;
    check({tag, " R3 sum dff"}, longint'(sum_d), longint'(tot % 2));
    check({tag, " R3 sum sr"},  longint'(sum_s), longint'(tot % 2));
    check({tag, " cout dff"},   longint'(cout_d), longint'(model_c));
    check({tag, " R6 cout sr"}, longint'(cout_s), longint'(model_c));
    s_out = sum_d;
    @(posedge clk);
    if (st) model_c = int'(ci);
    else if (v) model_c = tot / 2;
  endtask

  task automatic add_word(input int w, input longint unsigned a, input longint unsigned b,
                          input logic ci, input string tag);
    logic s;
    longint unsigned got_sum = 0;
    longint unsigned full;
    step(1'b1, ci, 1'b0, 1'b0, 1'b0, {tag, " R2 load"}, s);
    for (int i = 0; i < w; i++) begin
      step(1'b0, 1'b0, 1'b1, a[i], b[i], {tag, " R4 bit"}, s);
      got_sum[i] = s;
    end
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, {tag, " R5 idle"}, s);
    full = a + b + longint'(ci);
    check({tag, " R7 word sum"}, longint'(got_sum), longint'(full & ((64'd1 << w) - 1)));
    check({tag, " R7 cout dff"}, longint'(cout_d), longint'((full >> w) & 1));
    check({tag, " R7 cout sr"},  longint'(cout_s), longint'((full >> w) & 1));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic s;
    repeat (3) @(negedge clk);
    check("R1 reset cout dff", longint'(cout_d), 0);
    check("R1 reset cout sr",  longint'(cout_s), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: start beats valid
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 load one", s);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R2 start priority", s);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 after", s);

    // R5: idle ignores operand and carry-in
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R5 idle 11", s);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 load", s);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 idle 00", s);

    // R6: unequal pairs hold a carry of one, then zero
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R6 hold 10", s);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R6 hold 01", s);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R6 clear 00", s);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R6 hold 01 zero", s);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R6 set 11", s);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 after", s);

    // R7: exhaustive 4-bit words
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int c = 0; c < 2; c++)
          add_word(4, longint'(x), longint'(y), logic'(c), "R7 exh4");

    // R7: full-length ripple
    add_word(24, 64'hFFFFFF, 64'h0, 1'b1, "R7 ripple");
    add_word(24, 64'hFFFFFF, 64'hFFFFFF, 1'b1, "R7 all ones");

    // R7: random 16-bit words
    for (int k = 0; k < 40; k++)
      add_word(16, longint'($urandom_range(65535)), longint'($urandom_range(65535)),
               logic'($urandom_range(1)), "R7 rand16");

    // R1: reset during a word
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1 pre", s);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R1 pre bit", s);
    @(negedge clk);
    start = 1'b0; valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 async clear dff", longint'(cout_d), 0);
    check("R1 async clear sr",  longint'(cout_s), 0);
    model_c = 0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release dff", longint'(cout_d), 0);
    add_word(8, 64'hA5, 64'h5B, 1'b0, "R7 post reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule